// File: doc/BRIEF.md
# Multi-Mode Pulse Width Counter

This block is an 8-bit counter that serves three purposes. It can run as a free-running interval timer that flags each wrap. It can run as a down-counting reload timer that flips an output pin each time it expires. It can also time the waveform on an external pin. In measurement mode it can report the high time, the low time, the rising-to-rising or falling-to-falling period, or the high time and the period of one input cycle together. The counter advances on a count enable taken from an instruction-cycle tick, which is divided by 1, 4 or 32. Before the pin reaches the counter, it passes through a synchronizer and an edge detector.

Software starts the block with a start pulse, which latches the mode, measurement selection, divider, continuous bit and reload value. A stop pulse halts it. In single-shot measurement the block stops by itself after the first result. In continuous measurement it rearms after every result. Results leave on a valid/ready stream. The block never stalls a measurement to wait for a consumer. Width and period results each have their own holding slot. A result that arrives while its slot is still unread replaces the old value and sets the lost flag. When both slots hold data, the width slot is offered first. Sticky flags record that a result or expiry happened, that the counter wrapped, and that a result was lost. They are ORed into an interrupt when the interrupt is enabled.

Top module: `pwidth_timer`

## Requirements
- R1: After reset, `cap_valid_o`, `toggle_o`, `running_o`, `done_o`, `ovf_o`, `lost_o` and `irq_o` are all 0.
- R2: The count enable fires once every 1, 4 or 32 ticks for `div_i` = 0, 1 or 2 (3 acts as 32). With the tick held high and reload value R, the toggle pin therefore changes every (R+1)·D clocks.
- R3: In reload mode (`mode_i`=1), the counter is loaded with R at start and counts down. On a count at zero it reloads R, inverts `toggle_o` and sets `done_o`. `toggle_o` is cleared by start and otherwise changes only while running.
- R4: In interval mode (`mode_i`=0, and also 3), the counter counts up from 0 after start. The count that wraps it from 255 to 0 sets `ovf_o`, 256 counts after start.
- R5: Measurement (`mode_i`=2) with `sel_i`=0 gives the number of counts from a rising edge to the next falling edge. The result appears with `cap_period_o`=0.
- R6: With `sel_i`=1, measurement gives the counts from a falling edge to the next rising edge, with `cap_period_o`=0.
- R7: With `sel_i`=2 the result is the rising-to-rising period, and with `sel_i`=3 it is the falling-to-falling period, both with `cap_period_o`=1. Values 5 to 7 act as 0.
- R8: With `sel_i`=4, each input cycle yields two results. The high width is produced at the falling edge (`cap_period_o`=0), and the period is produced at the following rising edge (`cap_period_o`=1).
- R9: With `cont_i`=0, `running_o` drops after the first result. With `cont_i`=1 measurement rearms without a new start; in period modes the terminating edge opens the next measurement. `running_o` falls only after a stop or a result.
- R10: If the counter wraps during a measurement, the result's value is the count modulo 256, `cap_bad_o` is 1 for that result, and `ovf_o` is set.
- R11: A result holds `cap_valid_o` and its value until `cap_ready_i` is seen high. A new result that lands in an unread slot replaces that slot's value and sets `lost_o`.
- R12: `irq_o` is 1 exactly when `irq_en_i` is 1 and `done_o` or `ovf_o` is 1. A `flag_clr_i` pulse clears `done_o`, `ovf_o` and `lost_o`, and it takes priority over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle tick feeding the divider |
| pin_i | input | 1 | Asynchronous input pin being timed |
| start_i | input | 1 | Start pulse; latches configuration |
| stop_i | input | 1 | Stop pulse |
| mode_i | input | 2 | 0 interval, 1 reload, 2 measure, 3 interval |
| sel_i | input | 3 | Measurement selection (see R5 to R8) |
| div_i | input | 2 | Count divider select: 1, 4, 32 |
| cont_i | input | 1 | Continuous measurement enable |
| reload_i | input | 8 | Reload value |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for sticky flags |
| cap_ready_i | input | 1 | Consumer ready for result stream |
| cap_valid_o | output | 1 | Result stream valid |
| cap_value_o | output | 8 | Result count |
| cap_period_o | output | 1 | 1 for period result, 0 for width result |
| cap_bad_o | output | 1 | Result overflowed during measurement |
| toggle_o | output | 1 | Reload toggle pin |
| running_o | output | 1 | Counter is active |
| done_o | output | 1 | Sticky result/expiry flag |
| ovf_o | output | 1 | Sticky wrap flag |
| lost_o | output | 1 | Sticky overwritten-result flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for the stream-hold rule, for a result always raising valid on the next cycle, and for the flag clear winning over sets. It also checks that the interrupt never appears while disabled, that the toggle pin moves only while running or on a start, and that `running_o` falls only after a stop or a result. Only the bench scenarios can show the measured values for each selection, the two-result ordering of the combined mode, the toggle spacing per divider, the interval wrap time, the wrap-flagged result, and the replacement of an unread result.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    MD_INTERVAL = 2'd0,
    MD_RELOAD   = 2'd1,
    MD_MEASURE  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    MS_HIGH     = 3'd0,
    MS_LOW      = 3'd1,
    MS_RISE     = 3'd2,
    MS_FALL     = 3'd3,
    MS_PER_HIGH = 3'd4
  } msel_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RUN   = 3'd1,
    S_ARM   = 3'd2,
    S_MEAS  = 3'd3,
    S_MEAS2 = 3'd4
  } state_e;

  localparam int NUM_SLOTS = 2;
  localparam int SLOT_WID  = 0;
  localparam int SLOT_PER  = 1;
endpackage

// File: rtl/pwt_prescale.sv
module pwt_prescale #(
  parameter int DIV_A = 1,
  parameter int DIV_B = 4,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] div_sel,
  output logic       cen
);
  localparam int PW = (DIV_C > 1) ? $clog2(DIV_C) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  always_comb begin
    case (div_sel)
      2'd0:    lim = PW'(DIV_A - 1);
      2'd1:    lim = PW'(DIV_B - 1);
      default: lim = PW'(DIV_C - 1);
    endcase
  end

  assign cen = tick && (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clr)     pre_q <= '0;
    else if (tick)    pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/pwt_edge.sv
module pwt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pwt_core.sv
module pwt_core
  import pwt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [1:0]    mode_in,
  input  logic [2:0]    sel_in,
  input  logic [1:0]    div_in,
  input  logic          cont_in,
  input  logic [CW-1:0] reload_in,
  input  logic          cen,
  input  logic          rise,
  input  logic          fall,
  output logic [1:0]    div_q,
  output logic          running,
  output logic          toggle,
  output logic          wrap_ev,
  output logic          expire_ev,
  output logic          wid_ev,
  output logic          per_ev,
  output logic [CW-1:0] cap_val,
  output logic          cap_bad
);
  mode_e         mode_q, mode_n;
  msel_e         sel_q, sel_n;
  state_e        st_q;
  logic          cont_q;
  logic [CW-1:0] rel_q;
  logic [CW-1:0] cnt_q;
  logic          bad_q;
  logic          tog_q;
  logic          at_max;
  logic          counting;
  logic          open_edge;
  logic [CW-1:0] first_cnt;

  // configuration decode: unused codes fold onto defined ones
  always_comb begin
    mode_n = (mode_in == 2'd3) ? MD_INTERVAL : mode_e'(mode_in);
    sel_n  = (sel_in > 3'd4)   ? MS_HIGH     : msel_e'(sel_in);
  end

  assign at_max    = &cnt_q;
  assign first_cnt = CW'(cen);
  assign open_edge = (sel_q == MS_LOW || sel_q == MS_FALL) ? fall : rise;
  assign counting  = (st_q == S_MEAS) || (st_q == S_MEAS2) ||
                     (st_q == S_RUN && mode_q == MD_INTERVAL);

  always_comb begin
    wid_ev = 1'b0;
    per_ev = 1'b0;
    if (st_q == S_MEAS) begin
      case (sel_q)
        MS_HIGH:     wid_ev = fall;
        MS_LOW:      wid_ev = rise;
        MS_RISE:     per_ev = rise;
        MS_FALL:     per_ev = fall;
        MS_PER_HIGH: wid_ev = fall;
        default:     wid_ev = fall;
      endcase
    end else if (st_q == S_MEAS2) begin
      per_ev = rise;
    end
  end

  assign wrap_ev   = cen && at_max && counting;
  assign expire_ev = cen && (st_q == S_RUN) && (mode_q == MD_RELOAD) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_INTERVAL;
      sel_q  <= MS_HIGH;
      st_q   <= S_IDLE;
      cont_q <= 1'b0;
      div_q  <= 2'd0;
      rel_q  <= '0;
      cnt_q  <= '0;
      bad_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else if (start) begin
      mode_q <= mode_n;
      sel_q  <= sel_n;
      cont_q <= cont_in;
      div_q  <= div_in;
      rel_q  <= reload_in;
      cnt_q  <= (mode_n == MD_RELOAD) ? reload_in : '0;
      bad_q  <= 1'b0;
      tog_q  <= 1'b0;
      st_q   <= (mode_n == MD_MEASURE) ? S_ARM : S_RUN;
    end else if (stop) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_RUN: begin
          if (cen) begin
            if (mode_q == MD_RELOAD) begin
              if (cnt_q == '0) begin
                cnt_q <= rel_q;
                tog_q <= ~tog_q;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_ARM: begin
          if (open_edge) begin
            cnt_q <= first_cnt;
            bad_q <= 1'b0;
            st_q  <= S_MEAS;
          end
        end
        S_MEAS, S_MEAS2: begin
          if (per_ev) begin
            cnt_q <= first_cnt;
            bad_q <= 1'b0;
            st_q  <= cont_q ? S_MEAS : S_IDLE;
          end else if (wid_ev && sel_q == MS_PER_HIGH) begin
            if (cen) cnt_q <= cnt_q + 1'b1;
            if (wrap_ev) bad_q <= 1'b1;
            st_q <= S_MEAS2;
          end else if (wid_ev) begin
            st_q <= cont_q ? S_ARM : S_IDLE;
          end else begin
            if (cen) cnt_q <= cnt_q + 1'b1;
            if (wrap_ev) bad_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign running = (st_q != S_IDLE);
  assign toggle  = tog_q;
  assign cap_val = cnt_q;
  assign cap_bad = bad_q;
endmodule

// File: rtl/pwt_capbuf.sv
module pwt_capbuf
  import pwt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wid_ev,
  input  logic          per_ev,
  input  logic [CW-1:0] val_in,
  input  logic          bad_in,
  input  logic          expire_ev,
  input  logic          wrap_ev,
  input  logic          flag_clr,
  input  logic          ready,
  output logic          valid,
  output logic [CW-1:0] value,
  output logic          is_period,
  output logic          bad,
  output logic          done,
  output logic          ovf,
  output logic          lost
);
  logic [NUM_SLOTS-1:0]         put;
  logic [NUM_SLOTS-1:0]         full;
  logic [NUM_SLOTS-1:0]         take;
  logic [NUM_SLOTS-1:0]         over;
  logic [NUM_SLOTS-1:0]         sbad;
  logic [NUM_SLOTS-1:0][CW-1:0] sval;
  logic                         pick_per;
  logic                         pop;
  logic                         done_q, ovf_q, lost_q;

  assign put[SLOT_WID] = wid_ev;
  assign put[SLOT_PER] = per_ev;

  // width slot holds the older result of a combined cycle, so it goes first
  assign pick_per = !full[SLOT_WID];
  assign valid    = |full;
  assign pop      = valid && ready;
  assign take[SLOT_WID] = pop && !pick_per;
  assign take[SLOT_PER] = pop && pick_per;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic          f_q;
    logic          b_q;
    logic [CW-1:0] v_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        b_q <= 1'b0;
        v_q <= '0;
      end else if (put[g]) begin
        f_q <= 1'b1;
        b_q <= bad_in;
        v_q <= val_in;
      end else if (take[g]) begin
        f_q <= 1'b0;
      end
    end

    assign full[g] = f_q;
    assign sbad[g] = b_q;
    assign sval[g] = v_q;
    assign over[g] = put[g] && f_q && !take[g];
  end

  assign value     = pick_per ? sval[SLOT_PER] : sval[SLOT_WID];
  assign bad       = pick_per ? sbad[SLOT_PER] : sbad[SLOT_WID];
  assign is_period = pick_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      lost_q <= 1'b0;
    end else if (flag_clr) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      done_q <= done_q | (|put) | expire_ev;
      ovf_q  <= ovf_q | wrap_ev;
      lost_q <= lost_q | (|over);
    end
  end

  assign done = done_q;
  assign ovf  = ovf_q;
  assign lost = lost_q;
endmodule

// File: rtl/pwidth_timer.sv
module pwidth_timer #(
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 1,
  parameter int DIV_B       = 4,
  parameter int DIV_C       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          pin_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    mode_i,
  input  logic [2:0]    sel_i,
  input  logic [1:0]    div_i,
  input  logic          cont_i,
  input  logic [CW-1:0] reload_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  input  logic          cap_ready_i,
  output logic          cap_valid_o,
  output logic [CW-1:0] cap_value_o,
  output logic          cap_period_o,
  output logic          cap_bad_o,
  output logic          toggle_o,
  output logic          running_o,
  output logic          done_o,
  output logic          ovf_o,
  output logic          lost_o,
  output logic          irq_o
);
  logic          cen, rise, fall;
  logic [1:0]    div_q;
  logic          wrap_ev, expire_ev, wid_ev, per_ev;
  logic [CW-1:0] cap_val;
  logic          cap_bad;
  logic          cap_any;

  pwt_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .tick(tick_i),
    .div_sel(div_q), .cen(cen)
  );

  pwt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_i), .rise(rise), .fall(fall)
  );

  pwt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_i), .stop(stop_i),
    .mode_in(mode_i), .sel_in(sel_i), .div_in(div_i), .cont_in(cont_i),
    .reload_in(reload_i), .cen(cen), .rise(rise), .fall(fall),
    .div_q(div_q), .running(running_o), .toggle(toggle_o),
    .wrap_ev(wrap_ev), .expire_ev(expire_ev), .wid_ev(wid_ev),
    .per_ev(per_ev), .cap_val(cap_val), .cap_bad(cap_bad)
  );

  pwt_capbuf #(.CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wid_ev(wid_ev), .per_ev(per_ev),
    .val_in(cap_val), .bad_in(cap_bad), .expire_ev(expire_ev),
    .wrap_ev(wrap_ev), .flag_clr(flag_clr_i), .ready(cap_ready_i),
    .valid(cap_valid_o), .value(cap_value_o), .is_period(cap_period_o),
    .bad(cap_bad_o), .done(done_o), .ovf(ovf_o), .lost(lost_o)
  );

  assign cap_any = wid_ev | per_ev;
  assign irq_o   = irq_en_i & (done_o | ovf_o);
endmodule

// File: rtl/pwidth_timer_chk.sv
module pwidth_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic flag_clr_i,
  input logic irq_en_i,
  input logic cap_ready_i,
  input logic cap_valid_o,
  input logic toggle_o,
  input logic running_o,
  input logic done_o,
  input logic ovf_o,
  input logic lost_o,
  input logic irq_o,
  input logic cap_any
);
  // R11: an unaccepted result stays offered
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid_o && !cap_ready_i) |=> cap_valid_o);

  // R11: every result from the counter reaches the stream
  assert_result_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_any |=> cap_valid_o);

  // R12: clear empties all sticky flags
  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i |=> (!done_o && !ovf_o && !lost_o));

  // R12: no request while disabled
  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i);

  // R3: toggle pin moves only while running or on a start
  assert_toggle_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(toggle_o) |-> ($past(running_o) || $past(start_i)));

  // R9: running ends only on stop or a result
  assert_stop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> ($past(stop_i) || $past(cap_any)));
endmodule

bind pwidth_timer pwidth_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i), .cap_ready_i(cap_ready_i),
  .cap_valid_o(cap_valid_o), .toggle_o(toggle_o), .running_o(running_o),
  .done_o(done_o), .ovf_o(ovf_o), .lost_o(lost_o), .irq_o(irq_o),
  .cap_any(cap_any)
);

// File: tb/test_pwidth_timer.sv
module test_pwidth_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b1;
  logic          pin_i = 1'b0;
  logic          start_i = 1'b0, stop_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [2:0]    sel_i = 3'd0;
  logic [1:0]    div_i = 2'd0;
  logic          cont_i = 1'b0;
  logic [CW-1:0] reload_i = '0;
  logic          irq_en_i = 1'b0, flag_clr_i = 1'b0, cap_ready_i = 1'b1;
  logic          cap_valid_o, cap_period_o, cap_bad_o;
  logic [CW-1:0] cap_value_o;
  logic          toggle_o, running_o, done_o, ovf_o, lost_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [CW+1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  pwidth_timer i_pwidth_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
    .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i), .sel_i(sel_i),
    .div_i(div_i), .cont_i(cont_i), .reload_i(reload_i), .irq_en_i(irq_en_i),
    .flag_clr_i(flag_clr_i), .cap_ready_i(cap_ready_i),
    .cap_valid_o(cap_valid_o), .cap_value_o(cap_value_o),
    .cap_period_o(cap_period_o), .cap_bad_o(cap_bad_o), .toggle_o(toggle_o),
    .running_o(running_o), .done_o(done_o), .ovf_o(ovf_o), .lost_o(lost_o),
    .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_item(input bit per, input bit bad, input int val, input string tag);
    exp_q.push_back({per, bad, CW'(val)});
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cap_valid_o && cap_ready_i) begin
      logic [CW+1:0] got;
      got = {cap_period_o, cap_bad_o, cap_value_o};
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected result", int'(got), -1);
      end else begin
        logic [CW+1:0] want;
        string t;
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == want, t, int'(got), int'(want));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input int md, input int sel, input int dv, input bit cont, input int rl);
    mode_i = 2'(md); sel_i = 3'(sel); div_i = 2'(dv); cont_i = cont; reload_i = CW'(rl);
    start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic halt();
    stop_i = 1'b1;
    cyc(1);
    stop_i = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr_i = 1'b1;
    cyc(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    pin_i = v;
    cyc(n);
  endtask

  task automatic toggle_gap(input int expc, input string tag);
    logic t0;
    int n;
    t0 = toggle_o; n = 0;
    while (toggle_o == t0 && n < 500) begin cyc(1); n++; end
    t0 = toggle_o; n = 0;
    while (toggle_o == t0 && n < 500) begin cyc(1); n++; end
    check(n == expc, tag, n, expc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check({cap_valid_o, toggle_o, running_o, done_o, ovf_o, lost_o, irq_o} == 7'd0,
          "R1 reset outputs", int'({cap_valid_o, toggle_o, running_o, done_o, ovf_o, lost_o, irq_o}), 0);

    // R5 high width, single shot
    go(2, 0, 0, 1'b0, 0);
    expect_item(1'b0, 1'b0, 20, "R5 high width");
    hold(0, 3); hold(1, 20); hold(0, 8);
    check(running_o == 1'b0, "R9 single shot stops", running_o, 0);

    // R6 low width
    hold(1, 5);
    go(2, 1, 0, 1'b0, 0);
    expect_item(1'b0, 1'b0, 33, "R6 low width");
    hold(1, 3); hold(0, 33); hold(1, 8);

    // R7 rise-to-rise period
    hold(0, 5);
    go(2, 2, 0, 1'b0, 0);
    expect_item(1'b1, 1'b0, 25, "R7 rise period");
    hold(0, 3); hold(1, 10); hold(0, 15); hold(1, 8);

    // R7 fall-to-fall period
    go(2, 3, 0, 1'b0, 0);
    expect_item(1'b1, 1'b0, 19, "R7 fall period");
    hold(1, 3); hold(0, 7); hold(1, 12); hold(0, 8);

    // R8 combined width and period, continuous
    go(2, 4, 0, 1'b1, 0);
    expect_item(1'b0, 1'b0, 9,  "R8 combined width 1");
    expect_item(1'b1, 1'b0, 23, "R8 combined period 1");
    expect_item(1'b0, 1'b0, 5,  "R8 combined width 2");
    expect_item(1'b1, 1'b0, 11, "R8 combined period 2");
    hold(0, 3); hold(1, 9); hold(0, 14); hold(1, 5); hold(0, 6); hold(1, 6);
    check(running_o == 1'b1, "R9 continuous keeps running", running_o, 1);
    halt();
    check(running_o == 1'b0, "R9 stop ends run", running_o, 0);

    // R9 continuous high widths
    hold(0, 5);
    go(2, 0, 0, 1'b1, 0);
    expect_item(1'b0, 1'b0, 4,  "R9 continuous width 1");
    expect_item(1'b0, 1'b0, 7,  "R9 continuous width 2");
    expect_item(1'b0, 1'b0, 12, "R9 continuous width 3");
    hold(0, 3); hold(1, 4); hold(0, 5); hold(1, 7); hold(0, 5); hold(1, 12); hold(0, 6);
    halt();

    // R10 overflow during measurement
    clr_flags();
    go(2, 0, 0, 1'b0, 0);
    expect_item(1'b0, 1'b1, 300 % 256, "R10 wrapped width");
    hold(0, 3); hold(1, 300); hold(0, 8);
    check(ovf_o == 1'b1, "R10 overflow flag", ovf_o, 1);

    // R12 interrupt gating and flag clear
    check(irq_o == 1'b0, "R12 irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    cyc(1);
    check(irq_o == 1'b1, "R12 irq enabled", irq_o, 1);
    clr_flags();
    check({done_o, ovf_o, lost_o, irq_o} == 4'd0, "R12 flags cleared",
          int'({done_o, ovf_o, lost_o, irq_o}), 0);
    irq_en_i = 1'b0;

    // R11 back-pressure and overwrite
    cap_ready_i = 1'b0;
    go(2, 0, 0, 1'b1, 0);
    hold(0, 3); hold(1, 6); hold(0, 8);
    check(cap_valid_o == 1'b1, "R11 valid held", cap_valid_o, 1);
    check(cap_value_o == CW'(6), "R11 value held", cap_value_o, 6);
    check(lost_o == 1'b0, "R11 nothing lost yet", lost_o, 0);
    hold(1, 8); hold(0, 8);
    check(cap_value_o == CW'(8), "R11 value replaced", cap_value_o, 8);
    check(lost_o == 1'b1, "R11 lost flag", lost_o, 1);
    halt();
    expect_item(1'b0, 1'b0, 8, "R11 replaced item delivered");
    cap_ready_i = 1'b1;
    cyc(3);
    check(cap_valid_o == 1'b0, "R11 drained", cap_valid_o, 0);

    // R3 / R2 reload toggle spacing for each divider
    clr_flags();
    go(1, 0, 0, 1'b0, 5);
    toggle_gap(6, "R2 R3 reload div1");
    check(done_o == 1'b1, "R3 expiry sets done", done_o, 1);
    halt();
    go(1, 0, 1, 1'b0, 3);
    toggle_gap(16, "R2 reload div4");
    halt();
    go(1, 0, 2, 1'b0, 1);
    toggle_gap(64, "R2 reload div32");
    halt();

    // R4 interval wrap
    clr_flags();
    go(0, 0, 0, 1'b0, 0);
    cyc(250);
    check(ovf_o == 1'b0, "R4 no wrap before 256", ovf_o, 0);
    cyc(12);
    check(ovf_o == 1'b1, "R4 wrap after 256", ovf_o, 1);
    halt();

    cyc(5);
    check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule